// File: doc/BRIEF.md
# MII Carrier, Collision and Receive-Error Signalling

This block produces the per-port status outputs that a 10/100 transceiver channel presents to its MAC or repeater. Carrier sense and collision come from transmit enable and receive activity through combinational logic. They are shaped by the duplex mode, by a control that makes carrier sense follow the receive side only, and by the 10 Mbit/s serial mode. In serial mode the collision pin carries the jabber-expired status instead.

On the receive side the block takes error events that upstream logic has already classified: code error, premature end, link error and packet error. In 100 Mbit/s mode it registers these with data-valid and the receive nibble on the receive clock. While the error flag is high, the nibble carries a distinct code for the highest-priority error present. Two enable flops control packet-error and link-error reporting. On the transmit side a transmit-error request makes the next code group a fixed corrupt pattern.

Top module: `mii_status_sig`

## Requirements
- R1: In half duplex with `crs_rx_only` low, `crs` equals `tx_en | rx_active`, and it stays high while both are high.
- R2: When `crs_rx_only` is high or `full_duplex` is high, `crs` equals `rx_active` and does not depend on `tx_en`.
- R3: In half duplex outside serial mode, `col` equals `tx_en & rx_active`. It is combinational and settles without a clock edge.
- R4: `col` is low whenever `full_duplex` is high. In half duplex with `serial10` high, `col` equals `jabber`.
- R5: `rx_dv` and `rxd` repeat `rx_dv_in` and `rxd_in` one clock later when no error is reported. `rx_er` is never raised while `speed100` is low.
- R6: With `speed100` high, an error registers as `rx_er`=1 one clock later, and `rxd` then carries a code. The codes are 5h for a code error, 4h for a premature end, 3h for a link error and 2h for a packet error. When several errors are present in one cycle, the code follows this priority: code error, then premature end, then link error, then packet error.
- R7: Packet errors are reported only if `rep_pkt_en` was high in the previous cycle. Link errors are reported only if `rep_link_en` was high in the previous cycle. A gated error leaves `rx_er` low and `rxd` equal to `rxd_in`.
- R8: `txg_out` is `txg_in` one clock later. When `tx_er` is high, `txg_out` is instead the pattern 5'b00100.
- R9: During synchronous active-low reset, `rx_dv`, `rx_er`, `rxd` and `txg_out` are zero, and both report enables are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive/transmit symbol clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmit side not idle |
| rx_active | input | 1 | Receive side not idle |
| full_duplex | input | 1 | Full-duplex operation |
| crs_rx_only | input | 1 | Carrier sense from receive activity only |
| serial10 | input | 1 | 10 Mbit/s serial mode (collision pin shows jabber) |
| jabber | input | 1 | Jabber timer expired |
| speed100 | input | 1 | 100 Mbit/s mode |
| rep_pkt_en | input | 1 | Report packet errors (registered) |
| rep_link_en | input | 1 | Report link errors (registered) |
| ev_code | input | 1 | Code error this cycle |
| ev_premature | input | 1 | Premature end this cycle |
| ev_link | input | 1 | Link error this cycle |
| ev_packet | input | 1 | Packet error this cycle |
| rx_dv_in | input | 1 | Decoded data valid |
| rxd_in | input | 4 | Decoded receive nibble |
| tx_er | input | 1 | Transmit error request |
| txg_in | input | 5 | Code group from the encoder |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision / jabber indication |
| rx_dv | output | 1 | Registered data valid |
| rx_er | output | 1 | Registered receive error |
| rxd | output | 4 | Registered receive nibble or error code |
| txg_out | output | 5 | Registered, possibly corrupted code group |

## Verification
A stale report-enable flop shows up as a packet or link error that is reported, or suppressed, one cycle after software changed the control. The bench catches this by flipping an enable and sending an error in the very next cycle. A wrong priority or code value appears on `rxd` in the cycle after the overlapping events. A mis-selected carrier or collision source appears on `crs` or `col` within the same cycle. The bench checks those two outputs a nanosecond after the inputs change, with no clock edge in between.

// File: rtl/mii_status_pkg.sv
// Shared types and constants for the MII status signalling block.
package mii_status_pkg;
    localparam int NIB_W_DEF = 4;
    localparam int CG_W_DEF  = 5;

    // Error nibble codes driven on rxd while rx_er is high.
    typedef enum logic [3:0] {
        ERR_NONE      = 4'h0,
        ERR_PACKET    = 4'h2,
        ERR_LINK      = 4'h3,
        ERR_PREMATURE = 4'h4,
        ERR_CODE      = 4'h5
    } err_code_e;

    // Classified receive error events for one cycle.
    typedef struct packed {
        logic code;
        logic premature;
        logic link;
        logic packet;
    } err_ev_t;
endpackage

// File: rtl/mii_carrier_col.sv
// Combinational carrier sense and collision generation.
// Assumes all inputs are already synchronous to the port clock.
module mii_carrier_col (
    input  logic tx_en,
    input  logic rx_active,
    input  logic full_duplex,
    input  logic crs_rx_only,
    input  logic serial10,
    input  logic jabber,
    output logic crs,
    output logic col
);
    logic rx_only_src;

    // Choose the carrier source: receive only, or either direction.
    always_comb begin
        rx_only_src = full_duplex | crs_rx_only;
        crs = rx_only_src ? rx_active : (tx_en | rx_active);
    end

    // Collision: off in full duplex, jabber in serial mode, else overlap.
    always_comb begin
        if (full_duplex)
            col = 1'b0;
        else if (serial10)
            col = jabber;
        else
            col = tx_en & rx_active;
    end
endmodule

// File: rtl/mii_err_select.sv
// Holds the two report-enable flops and picks the highest-priority
// reportable error code for the current cycle. Output is combinational;
// the caller registers it. Assumes events are single-cycle qualified.
module mii_err_select
    import mii_status_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      speed100,
    input  logic      rep_pkt_en,
    input  logic      rep_link_en,
    input  err_ev_t   ev,
    output logic      err_hit,
    output err_code_e err_code
);
    logic pkt_en_q;
    logic link_en_q;
    err_ev_t gated;

    // Capture the report enables; they act from the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_en_q  <= 1'b0;
            link_en_q <= 1'b0;
        end else begin
            pkt_en_q  <= rep_pkt_en;
            link_en_q <= rep_link_en;
        end
    end

    // Drop events that are disabled or irrelevant at this speed.
    always_comb begin
        gated.code      = speed100 & ev.code;
        gated.premature = speed100 & ev.premature;
        gated.link      = speed100 & ev.link & link_en_q;
        gated.packet    = speed100 & ev.packet & pkt_en_q;
    end

    // Priority encode: code, premature end, link, packet.
    always_comb begin
        err_hit = |gated;
        if (gated.code)
            err_code = ERR_CODE;
        else if (gated.premature)
            err_code = ERR_PREMATURE;
        else if (gated.link)
            err_code = ERR_LINK;
        else if (gated.packet)
            err_code = ERR_PACKET;
        else
            err_code = ERR_NONE;
    end
endmodule

// File: rtl/mii_rx_stage.sv
// Output register for data-valid, error flag and receive nibble.
// Substitutes the error code into the nibble while an error is reported.
module mii_rx_stage
    import mii_status_pkg::*;
#(
    parameter int NIB_W = NIB_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dv_in,
    input  logic [NIB_W-1:0] nib_in,
    input  logic             err_hit,
    input  err_code_e        err_code,
    output logic             dv_q,
    output logic             er_q,
    output logic [NIB_W-1:0] nib_q
);
    localparam int CODE_W = $bits(err_code_e);
    logic [NIB_W-1:0] nib_next;

    // Widen the error code to the nibble width.
    generate
        if (NIB_W > CODE_W) begin : g_wide
            assign nib_next = err_hit ? {{(NIB_W-CODE_W){1'b0}}, err_code} : nib_in;
        end else begin : g_exact
            assign nib_next = err_hit ? err_code[NIB_W-1:0] : nib_in;
        end
    endgenerate

    // Register receive outputs on the receive clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dv_q  <= 1'b0;
            er_q  <= 1'b0;
            nib_q <= '0;
        end else begin
            dv_q  <= dv_in;
            er_q  <= err_hit;
            nib_q <= nib_next;
        end
    end
endmodule

// File: rtl/mii_tx_corrupt.sv
// Replaces the outgoing code group with a fixed corrupt pattern
// when a transmit error is requested. One register stage.
module mii_tx_corrupt #(
    parameter int               CG_W       = 5,
    parameter logic [CG_W-1:0]  CORRUPT_CG = CG_W'(5'b00100)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_er,
    input  logic [CG_W-1:0] cg_in,
    output logic [CG_W-1:0] cg_out
);
    // Register the code group, substituting on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cg_out <= '0;
        else
            cg_out <= tx_er ? CORRUPT_CG : cg_in;
    end
endmodule

// File: rtl/mii_status_sig.sv
// Per-port MII status signalling: carrier sense, collision, receive
// error coding and transmit error injection. Assumes one clock domain.
module mii_status_sig
    import mii_status_pkg::*;
#(
    parameter int NIB_W = NIB_W_DEF,
    parameter int CG_W  = CG_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             rx_active,
    input  logic             full_duplex,
    input  logic             crs_rx_only,
    input  logic             serial10,
    input  logic             jabber,
    input  logic             speed100,
    input  logic             rep_pkt_en,
    input  logic             rep_link_en,
    input  logic             ev_code,
    input  logic             ev_premature,
    input  logic             ev_link,
    input  logic             ev_packet,
    input  logic             rx_dv_in,
    input  logic [NIB_W-1:0] rxd_in,
    input  logic             tx_er,
    input  logic [CG_W-1:0]  txg_in,
    output logic             crs,
    output logic             col,
    output logic             rx_dv,
    output logic             rx_er,
    output logic [NIB_W-1:0] rxd,
    output logic [CG_W-1:0]  txg_out
);
    err_ev_t   ev;
    logic      err_hit;
    err_code_e err_code;

    // Bundle the classified events.
    always_comb begin
        ev.code      = ev_code;
        ev.premature = ev_premature;
        ev.link      = ev_link;
        ev.packet    = ev_packet;
    end

    mii_carrier_col u_cc (
        .tx_en       (tx_en),
        .rx_active   (rx_active),
        .full_duplex (full_duplex),
        .crs_rx_only (crs_rx_only),
        .serial10    (serial10),
        .jabber      (jabber),
        .crs         (crs),
        .col         (col)
    );

    mii_err_select u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .speed100    (speed100),
        .rep_pkt_en  (rep_pkt_en),
        .rep_link_en (rep_link_en),
        .ev          (ev),
        .err_hit     (err_hit),
        .err_code    (err_code)
    );

    mii_rx_stage #(.NIB_W(NIB_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .dv_in    (rx_dv_in),
        .nib_in   (rxd_in),
        .err_hit  (err_hit),
        .err_code (err_code),
        .dv_q     (rx_dv),
        .er_q     (rx_er),
        .nib_q    (rxd)
    );

    mii_tx_corrupt #(.CG_W(CG_W)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .tx_er  (tx_er),
        .cg_in  (txg_in),
        .cg_out (txg_out)
    );
endmodule

// File: rtl/mii_status_sig_chk.sv
// Property checker for mii_status_sig, attached by bind.
module mii_status_sig_chk #(
    parameter int NIB_W = 4,
    parameter int CG_W  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_en,
    input logic             rx_active,
    input logic             full_duplex,
    input logic             crs_rx_only,
    input logic             serial10,
    input logic             jabber,
    input logic             speed100,
    input logic             rep_pkt_en,
    input logic             ev_code,
    input logic             ev_premature,
    input logic             ev_link,
    input logic             ev_packet,
    input logic             tx_er,
    input logic             crs,
    input logic             col,
    input logic             rx_er,
    input logic [NIB_W-1:0] rxd,
    input logic [CG_W-1:0]  txg_out
);
    p_crs_either_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_duplex && !crs_rx_only && (tx_en || rx_active)) |-> crs);

    p_crs_rxonly_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (full_duplex || crs_rx_only) |-> (crs == rx_active));

    p_col_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_duplex && !serial10 && tx_en && rx_active) |-> col);

    p_col_fdx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        full_duplex |-> !col);

    p_col_jabber_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_duplex && serial10) |-> (col == jabber));

    p_no_err_10m_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !speed100 |=> !rx_er);

    p_code_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (speed100 && ev_code) |=> (rx_er && rxd == NIB_W'(4'h5)));

    p_premature_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (speed100 && !ev_code && ev_premature) |=> (rx_er && rxd == NIB_W'(4'h4)));

    p_pkt_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (speed100 && ev_packet && !ev_code && !ev_premature && !ev_link
         && !$past(rep_pkt_en)) |=> !rx_er);

    p_tx_corrupt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_er |=> (txg_out == CG_W'(5'b00100)));
endmodule

bind mii_status_sig mii_status_sig_chk #(.NIB_W(NIB_W), .CG_W(CG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_en        (tx_en),
    .rx_active    (rx_active),
    .full_duplex  (full_duplex),
    .crs_rx_only  (crs_rx_only),
    .serial10     (serial10),
    .jabber       (jabber),
    .speed100     (speed100),
    .rep_pkt_en   (rep_pkt_en),
    .ev_code      (ev_code),
    .ev_premature (ev_premature),
    .ev_link      (ev_link),
    .ev_packet    (ev_packet),
    .tx_er        (tx_er),
    .crs          (crs),
    .col          (col),
    .rx_er        (rx_er),
    .rxd          (rxd),
    .txg_out      (txg_out)
);

// File: tb/mii_status_sig_test.sv
`timescale 1ns/1ps
module mii_status_sig_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic tx_en, rx_active, full_duplex, crs_rx_only, serial10, jabber;
    logic speed100, rep_pkt_en, rep_link_en;
    logic ev_code, ev_premature, ev_link, ev_packet;
    logic rx_dv_in, tx_er;
    logic [3:0] rxd_in;
    logic [4:0] txg_in;
    logic crs, col, rx_dv, rx_er;
    logic [3:0] rxd;
    logic [4:0] txg_out;

    mii_status_sig uut (.*);

    typedef struct {
        logic tx, rx, fdx, sel, ser, jab, spd, pen, len;
        logic ec, ep, el, ek, dv, txer;
        logic [3:0] d;
        logic [4:0] g;
    } stim_t;

    typedef struct {
        logic er, dv;
        logic [3:0] d;
        logic [4:0] g;
        string tag;
    } exp_t;

    exp_t sb[$];
    int n_run = 0;
    int n_fail = 0;
    logic pen_q = 1'b0;
    logic len_q = 1'b0;
    bit done = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic stim_t idle();
        stim_t s;
        s.tx = 0; s.rx = 0; s.fdx = 0; s.sel = 0; s.ser = 0; s.jab = 0;
        s.spd = 1; s.pen = pen_q; s.len = len_q;
        s.ec = 0; s.ep = 0; s.el = 0; s.ek = 0; s.dv = 0; s.txer = 0;
        s.d = 4'h0; s.g = 5'h00;
        return s;
    endfunction

    // Driver: apply one cycle of stimulus, check comb outputs, queue registered ones.
    task automatic step(input stim_t s, input string tag);
        exp_t e;
        logic ecrs, ecol;
        logic rl, rk;
        @(negedge clk);
        tx_en = s.tx; rx_active = s.rx; full_duplex = s.fdx; crs_rx_only = s.sel;
        serial10 = s.ser; jabber = s.jab; speed100 = s.spd;
        rep_pkt_en = s.pen; rep_link_en = s.len;
        ev_code = s.ec; ev_premature = s.ep; ev_link = s.el; ev_packet = s.ek;
        rx_dv_in = s.dv; rxd_in = s.d; tx_er = s.txer; txg_in = s.g;
        #1;
        ecrs = (s.fdx || s.sel) ? s.rx : (s.tx || s.rx);
        ecol = s.fdx ? 1'b0 : (s.ser ? s.jab : (s.tx && s.rx));
        chk({tag, " crs"}, crs, ecrs);
        chk({tag, " col"}, col, ecol);
        rl = s.el && len_q;
        rk = s.ek && pen_q;
        e.er = s.spd && (s.ec || s.ep || rl || rk);
        e.d  = !e.er ? s.d : s.ec ? 4'h5 : s.ep ? 4'h4 : rl ? 4'h3 : 4'h2;
        e.dv = s.dv;
        e.g  = s.txer ? 5'b00100 : s.g;
        e.tag = tag;
        sb.push_back(e);
        pen_q = s.pen;
        len_q = s.len;
    endtask

    // Monitor: after each edge, compare registered outputs with the queue head.
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk({e.tag, " rx_er"}, rx_er, e.er);
            chk({e.tag, " rxd"}, rxd, e.d);
            chk({e.tag, " rx_dv"}, rx_dv, e.dv);
            chk({e.tag, " txg_out"}, txg_out, e.g);
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        stim_t s;
        // R9: reset with busy inputs.
        tx_en = 1; rx_active = 0; full_duplex = 0; crs_rx_only = 0; serial10 = 0;
        jabber = 0; speed100 = 1; rep_pkt_en = 1; rep_link_en = 1;
        ev_code = 1; ev_premature = 0; ev_link = 0; ev_packet = 0;
        rx_dv_in = 1; rxd_in = 4'hA; tx_er = 1; txg_in = 5'h1F;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset rx_er", rx_er, 0);
        chk("R9 reset rxd", rxd, 0);
        chk("R9 reset rx_dv", rx_dv, 0);
        chk("R9 reset txg_out", txg_out, 0);
        rep_pkt_en = 0; rep_link_en = 0;
        rst_n = 1'b1;
        pen_q = 0; len_q = 0;

        s = idle(); s.tx = 1;                 step(s, "R1 tx only");
        s = idle(); s.rx = 1;                 step(s, "R1 rx only");
        s = idle(); s.tx = 1; s.rx = 1;       step(s, "R1 R3 overlap");
        s = idle();                           step(s, "R1 idle");
        s = idle(); s.sel = 1; s.tx = 1;      step(s, "R2 sel tx only");
        s = idle(); s.sel = 1; s.tx = 1; s.rx = 1; step(s, "R2 sel both");
        s = idle(); s.fdx = 1; s.tx = 1;      step(s, "R2 fdx tx only");
        s = idle(); s.fdx = 1; s.tx = 1; s.rx = 1; step(s, "R4 fdx no col");
        s = idle(); s.ser = 1; s.jab = 1;     step(s, "R4 serial jabber");
        s = idle(); s.ser = 1; s.tx = 1; s.rx = 1; step(s, "R4 serial no jabber");
        s = idle(); s.fdx = 1; s.ser = 1; s.jab = 1; step(s, "R4 fdx over jabber");
        s = idle(); s.dv = 1; s.d = 4'hA;     step(s, "R5 data pass");
        s = idle(); s.dv = 1; s.d = 4'h9; s.ec = 1; s.ep = 1; s.el = 1; s.ek = 1;
                                              step(s, "R6 code first");
        s = idle(); s.dv = 1; s.d = 4'h9; s.ep = 1; s.el = 1; s.ek = 1;
                                              step(s, "R6 premature");
        s = idle(); s.dv = 1; s.d = 4'h6; s.el = 1; s.ek = 1;
                                              step(s, "R7 both gated");
        s = idle(); s.pen = 1; s.len = 1;     step(s, "R7 enable");
        s = idle(); s.dv = 1; s.d = 4'h7; s.el = 1; s.ek = 1;
                                              step(s, "R6 link over packet");
        s = idle(); s.d = 4'h8; s.ek = 1;     step(s, "R6 packet");
        s = idle(); s.pen = 0; s.len = 0; s.d = 4'h1; s.ek = 1;
                                              step(s, "R7 old enable used");
        s = idle(); s.d = 4'hC; s.ek = 1;     step(s, "R7 packet gated");
        s = idle(); s.d = 4'hB; s.el = 1;     step(s, "R7 link gated");
        s = idle(); s.spd = 0; s.dv = 1; s.d = 4'h3; s.ec = 1;
                                              step(s, "R5 no err at 10M");
        s = idle(); s.txer = 1; s.g = 5'h1F;  step(s, "R8 corrupt");
        s = idle(); s.g = 5'h15;              step(s, "R8 pass");
        s = idle();                           step(s, "R5 drain");
        repeat (3) @(posedge clk);
        #5;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule